// File: doc/BRIEF.md
# Presettable Down Divider with Cascade Gating

This block is a small synchronous binary down counter for frequency division. Two events decrement the count by one: a rising edge on the count clock, or a falling edge on the inhibit input. A raised inhibit also blocks count-clock edges. While the load request is high, the counter takes the parallel preset word, and this has priority over counting. The block decodes the all-zeros state onto a zero flag. That flag is gated by a chain-enable input, so several counters can form one multi-stage divider with no extra logic.

All external inputs are slow, asynchronous signals. Each one passes through a two-flop synchronizer on the fast system clock. Edges are found by comparing a synchronized input with its previous sample. For a single-stage divide-by-N, the chain-enable input is tied high and the zero flag is fed back to the load request. The counter then reloads N each time it reaches zero.

Top module: `down_divider`

## Requirements
- R1: While rst_ni is low, the count is 0000 and the zero flag is low. Once reset is released with chain_en_i high, the zero flag goes high.
- R2: With inhibit low, each rising edge of cnt_clk_i lowers the count by exactly one. A falling edge of cnt_clk_i has no effect.
- R3: A falling edge of inhibit_i lowers the count by exactly one. A rising edge of inhibit_i has no effect.
- R4: While inhibit_i is high, rising edges of cnt_clk_i leave the count unchanged.
- R5: While load_i is high, the count equals load_val_i and follows changes to it. Count events seen during the load are ignored.
- R6: zero_o is high exactly when the count is 0000 and chain_en_i is high. With chain_en_i low, zero_o stays low.
- R7: A decrement from 0000 gives 1111.
- R8: A count-clock rising edge and an inhibit falling edge seen in the same system cycle give a single decrement.
- R9: With zero_o fed back to load_i and load_val_i = N, the block gives one zero_o rising edge for every N count-clock rising edges.
- R10: An input change reaches the count on the third rising edge of clk_i after the change. This covers two synchronizer flops plus the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | fast system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| cnt_clk_i | input | 1 | count clock; a rising edge decrements |
| inhibit_i | input | 1 | blocks counting when high; a falling edge decrements |
| load_i | input | 1 | load request; a high level loads load_val_i |
| chain_en_i | input | 1 | enables the zero flag, used for chaining stages |
| load_val_i | input | WIDTH | parallel preset value |
| count_o | output | WIDTH | current count |
| zero_o | output | 1 | count is zero and chaining is enabled |

## Verification
The bench first drives the count clock alone, then inhibit used as a clock, then both sources switching in the same cycle. Comparing these three cases separates a missing second trigger source from a double decrement. The bench raises load while count edges arrive and changes the preset word during the load, which shows whether load has priority over counting and whether the load is level-sensitive. A run that starts from zero checks the wrap to 1111. A closed-loop run with the zero flag fed back to load checks the division ratio. Toggling the chain enable separates a plain zero decode from the gated flag.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic cnt_clk;
    logic inhibit;
    logic load;
    logic chain_en;
  } div_ctrl_t;

  localparam int unsigned CTRL_W = $bits(div_ctrl_t);
endpackage

// File: rtl/div_sync.sv
module div_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/div_edge.sv
module div_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_clk_i,
  input  logic inhibit_i,
  output logic event_o
);
  logic clk_prev_q, inh_prev_q;
  logic clk_rise, inh_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_prev_q <= 1'b0;
      inh_prev_q <= 1'b0;
    end else begin
      clk_prev_q <= cnt_clk_i;
      inh_prev_q <= inhibit_i;
    end
  end

  assign clk_rise = cnt_clk_i & ~clk_prev_q;
  assign inh_fall = ~inhibit_i & inh_prev_q;
  // coincident sources merge into one event
  assign event_o  = (clk_rise & ~inhibit_i) | inh_fall;
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o
);
  logic [WIDTH-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (load_i)  count_q <= load_val_i;
    else if (event_i) count_q <= count_q - WIDTH'(1);
  end

  assign count_o = count_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !load_i) |=> count_q == $past(count_q) - WIDTH'(1));
  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!event_i && !load_i) |=> $stable(count_q));
  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_q == $past(load_val_i));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && event_i && !load_i) |=> count_q == '1);
endmodule

// File: rtl/down_divider.sv
module down_divider
  import div_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_clk_i,
  input  logic             inhibit_i,
  input  logic             load_i,
  input  logic             chain_en_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             zero_o
);
  div_ctrl_t        ctrl_raw, ctrl_s;
  logic [WIDTH-1:0] load_val_s;
  logic             count_ev;

  assign ctrl_raw = '{cnt_clk: cnt_clk_i, inhibit: inhibit_i,
                      load: load_i, chain_en: chain_en_i};

  div_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_DEPTH)) u_sync_ctrl (
    .clk_i, .rst_ni, .d_i(ctrl_raw), .q_o(ctrl_s));

  div_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync_val (
    .clk_i, .rst_ni, .d_i(load_val_i), .q_o(load_val_s));

  div_edge u_edge (
    .clk_i, .rst_ni,
    .cnt_clk_i(ctrl_s.cnt_clk),
    .inhibit_i(ctrl_s.inhibit),
    .event_o(count_ev));

  div_core #(.WIDTH(WIDTH)) u_core (
    .clk_i, .rst_ni,
    .event_i(count_ev),
    .load_i(ctrl_s.load),
    .load_val_i(load_val_s),
    .count_o);

  assign zero_o = ctrl_s.chain_en && (count_o == '0);

  assert_inhibit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_s.inhibit && $past(ctrl_s.inhibit) && !ctrl_s.load) |=> $stable(count_o));
  assert_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_s.load |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - WIDTH'(1)));
endmodule

// File: tb/down_divider_test.sv
`timescale 1ns/1ps
module down_divider_test;
  logic       clk = 0, rst_ni = 0;
  logic       cnt_clk = 0, inhibit = 0, load_drv = 0, chain_en = 1, loop_mode = 0;
  logic [3:0] load_val = 0;
  logic [3:0] count;
  logic       zero, load;
  int total = 0, bad = 0, zero_rises = 0;
  logic zero_d = 0;

  typedef struct { logic [3:0] cnt; logic z; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;
  assign load = loop_mode ? zero : load_drv;

  down_divider uut (.clk_i(clk), .rst_ni, .cnt_clk_i(cnt_clk), .inhibit_i(inhibit),
    .load_i(load), .chain_en_i(chain_en), .load_val_i(load_val),
    .count_o(count), .zero_o(zero));

  always @(posedge clk) begin
    zero_d <= zero;
    if (loop_mode && zero && !zero_d) zero_rises++;
  end

  task automatic expect_now(input logic [3:0] c, input logic z, input string tag);
    item_t it;
    it.cnt = c; it.z = z; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle(input logic [3:0] c, input logic z, input string tag);
    repeat (4) @(posedge clk);
    @(negedge clk);
    expect_now(c, z, tag);
  endtask

  task automatic pulse_clk();
    @(negedge clk); cnt_clk = 1;
    repeat (6) @(negedge clk);
    cnt_clk = 0;
    repeat (6) @(negedge clk);
  endtask

  // monitor: pop expected items and compare with outputs
  initial forever begin
    item_t it;
    wait (q.size() != 0);
    it = q.pop_front();
    total++;
    if (count !== it.cnt || zero !== it.z) begin
      bad++;
      $display("FAIL %s: count=%0d zero=%0b expected count=%0d zero=%0b",
               it.tag, count, zero, it.cnt, it.z);
    end
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now(4'd0, 1'b0, "R1 in reset");
    rst_ni = 1;
    settle(4'd0, 1'b1, "R1 after reset");

    @(negedge clk); cnt_clk = 1; settle(4'd15, 1'b0, "R7 wrap");
    @(negedge clk); cnt_clk = 0; settle(4'd15, 1'b0, "R2 fall ignored");
    // R10: change lands on third clk_i edge
    @(negedge clk); cnt_clk = 1;
    repeat (2) @(posedge clk); @(negedge clk); expect_now(4'd15, 1'b0, "R10 not yet");
    @(posedge clk); @(negedge clk); expect_now(4'd14, 1'b0, "R10 third edge");
    @(negedge clk); cnt_clk = 0;
    pulse_clk(); settle(4'd13, 1'b0, "R2 second rise");

    @(negedge clk); load_val = 4'd9; load_drv = 1; settle(4'd9, 1'b0, "R5 load");
    pulse_clk(); settle(4'd9, 1'b0, "R5 overrides count");
    @(negedge clk); load_val = 4'd3; settle(4'd3, 1'b0, "R5 follows value");
    @(negedge clk); load_drv = 0; settle(4'd3, 1'b0, "R5 release");

    @(negedge clk); inhibit = 1; settle(4'd3, 1'b0, "R3 inhibit rise ignored");
    pulse_clk(); pulse_clk(); settle(4'd3, 1'b0, "R4 inhibited clock");
    @(negedge clk); inhibit = 0; settle(4'd2, 1'b0, "R3 inhibit fall");

    @(negedge clk); inhibit = 1; settle(4'd2, 1'b0, "R8 setup");
    @(negedge clk); inhibit = 0; cnt_clk = 1; settle(4'd1, 1'b0, "R8 coincident");
    @(negedge clk); cnt_clk = 0; settle(4'd1, 1'b0, "R8 after");

    @(negedge clk); inhibit = 1; settle(4'd1, 1'b0, "R3 setup");
    @(negedge clk); inhibit = 0; settle(4'd0, 1'b1, "R3 reach zero");
    @(negedge clk); chain_en = 0; settle(4'd0, 1'b0, "R6 gated");
    @(negedge clk); chain_en = 1; settle(4'd0, 1'b1, "R6 enabled");

    @(negedge clk); load_val = 4'd5; load_drv = 1; settle(4'd5, 1'b0, "R9 preload");
    @(negedge clk); load_drv = 0; loop_mode = 1;
    for (int i = 0; i < 15; i++) pulse_clk();
    settle(4'd5, 1'b0, "R9 reload");
    wait (q.size() == 0);
    #1;
    total++;
    if (zero_rises != 3) begin
      bad++;
      $display("FAIL R9 zero rises=%0d expected 3", zero_rises);
    end
    loop_mode = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule